// File: doc/BRIEF.md
# Dual-Issue Decode Interlock

This block is the read-after-write interlock for an in-order decode stage that handles two instructions per cycle. Each decoded instruction may read two source registers, A and B. Each source has an identifier, a read enable and a flag that marks it as a double-width operand. Every cycle the block checks those sources against the destination registers of the instructions now in the first and second execute stages. From that comparison it decides whether each decode slot must hold.

A double-width value always occupies an even register and the odd register just above it. The match logic therefore treats a double-width source or result as covering a pair of registers. An id match alone does not force a stall. A dependent operand can still be taken from the bypass network in three conditions: the consumer may use forwarding, the producer finishes in a single cycle, and operand and result have the same width. Issue is in order, so the second slot holds whenever the first slot holds. The global decode stall reports whether any slot holds. All outputs are combinational and follow the inputs within the same cycle.

Top module: `hazard_stall_unit`

## Requirements
- R1: Register ids are 4 bits wide. When operand and result have the same width, a match means the source id equals the destination id. For double-width values both ids are even.
- R2: A double-width source at even id S and a single-width result at id D match when D equals S or D equals S with bit 0 forced to 1.
- R3: A single-width source at id S and a double-width result at even id D match when S equals D or S equals D with bit 0 forced to 1.
- R4: A dependency exists only when four things hold: the ids match, the source read enable is 1, the producer write enable is 1, and both the decode slot and the execute entry are valid. Without a dependency the slot never stalls.
- R5: A dependent operand stalls its slot when the slot's forwarding enable is 0.
- R6: A dependent operand stalls its slot when the producer's two-cycle flag is 1.
- R7: A dependent operand stalls its slot when the operand's double-width flag differs from the producer's double-width flag.
- R8: A dependent operand does not stall when forwarding is enabled, the producer is single-cycle and the width flags agree.
- R9: Both source operands are checked against both execute stages. Execute stage index 0 is the first stage and index 1 is the second.
- R10: slot_stall[1] is 1 whenever slot_stall[0] is 1 (in-order issue). Slot 0 never stalls because of slot 1.
- R11: decode_stall is 1 exactly when any bit of slot_stall is 1.
- R12: slot_stall and decode_stall depend only on the present inputs and settle in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | NUM_SLOTS | Decode slot holds a real instruction |
| dec_fwd_en | input | NUM_SLOTS | Slot may take operands from the bypass network |
| dec_srca_id | input | NUM_SLOTS*4 | Source A register id, 4 bits per slot |
| dec_srca_rd | input | NUM_SLOTS | Source A is read |
| dec_srca_long | input | NUM_SLOTS | Source A is double-width |
| dec_srcb_id | input | NUM_SLOTS*4 | Source B register id, 4 bits per slot |
| dec_srcb_rd | input | NUM_SLOTS | Source B is read |
| dec_srcb_long | input | NUM_SLOTS | Source B is double-width |
| ex_valid | input | NUM_EX | Execute stage holds a real instruction |
| ex_dst_id | input | NUM_EX*4 | Destination register id, 4 bits per stage |
| ex_wr_en | input | NUM_EX | Stage instruction writes its destination |
| ex_long | input | NUM_EX | Destination is double-width |
| ex_two_cyc | input | NUM_EX | Stage instruction has two-cycle latency |
| slot_stall | output | NUM_SLOTS | Per-slot hold request, in-order chained |
| decode_stall | output | 1 | Any decode slot holds |

## Verification
Every result of this block is due in the same cycle as the stimulus that causes it, because the block has no registers. The bench applies a new input pattern just after a rising edge and compares both slot stalls and the global stall at the following falling edge. By then the combinational paths have settled and the next pattern has not yet been applied. A behavioural model that uses register-set overlap produces the expected values for that same half-cycle. Directed patterns cover each width combination and each stall reason for both operands and both stages. Random patterns, with small id ranges so that matches are frequent, then exercise the combinations between them.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;

  localparam int unsigned REG_ID_W = 4;

  typedef logic [REG_ID_W-1:0] reg_id_t;

  // one source operand of a decoded instruction
  typedef struct packed {
    reg_id_t id;
    logic    rd_en;
    logic    is_long;
  } src_opnd_t;

  // consumer view of a decode slot
  typedef struct packed {
    logic      valid;
    logic      fwd_en;
    src_opnd_t opa;
    src_opnd_t opb;
  } consumer_t;

  // producer view of an execute stage entry
  typedef struct packed {
    logic    valid;
    reg_id_t dst;
    logic    wr_en;
    logic    is_long;
    logic    two_cyc;
  } producer_t;

  // odd member of an even/odd register pair
  function automatic reg_id_t pair_hi(input reg_id_t id);
    return {id[REG_ID_W-1:1], 1'b1};
  endfunction

endpackage

// File: rtl/hz_id_match.sv
`timescale 1ns/1ps
module hz_id_match
  import hazard_pkg::*;
(
  input  src_opnd_t src,
  input  producer_t prod,
  output logic      hit
);

  reg_id_t src_hi;
  reg_id_t dst_hi;
  logic    eq_direct;
  logic    eq_src_hi;
  logic    eq_dst_hi;

  always_comb begin
    src_hi    = pair_hi(src.id);
    dst_hi    = pair_hi(prod.dst);
    eq_direct = (src.id == prod.dst);
    // long source covers its odd partner
    eq_src_hi = src.is_long & (src_hi == prod.dst);
    // long result covers its odd partner
    eq_dst_hi = prod.is_long & (src.id == dst_hi);
    hit       = eq_direct | eq_src_hi | eq_dst_hi;
  end

endmodule

// File: rtl/hz_operand_check.sv
`timescale 1ns/1ps
module hz_operand_check
  import hazard_pkg::*;
(
  input  logic      cons_valid,
  input  logic      cons_fwd_en,
  input  src_opnd_t src,
  input  producer_t prod,
  output logic      stall
);

  logic hit;
  logic dep;
  logic no_bypass;

  hz_id_match u_match (
    .src  (src),
    .prod (prod),
    .hit  (hit)
  );

  always_comb begin
    dep       = hit & src.rd_en & prod.wr_en & cons_valid & prod.valid;
    no_bypass = ~cons_fwd_en | prod.two_cyc | (src.is_long ^ prod.is_long);
    stall     = dep & no_bypass;
  end

endmodule

// File: rtl/hz_slot_check.sv
`timescale 1ns/1ps
module hz_slot_check
  import hazard_pkg::*;
#(
  parameter int unsigned NUM_EX = 2
) (
  input  consumer_t              cons,
  input  producer_t [NUM_EX-1:0] prods,
  output logic                   own_stall
);

  localparam int unsigned NUM_OPND = 2;
  localparam int unsigned NUM_CHK  = NUM_EX * NUM_OPND;

  logic [NUM_CHK-1:0] chk_stall;

  for (genvar e = 0; e < NUM_EX; e++) begin : g_stage
    for (genvar o = 0; o < NUM_OPND; o++) begin : g_opnd
      src_opnd_t sel_src;
      if (o == 0) begin : g_a
        assign sel_src = cons.opa;
      end else begin : g_b
        assign sel_src = cons.opb;
      end
      hz_operand_check u_chk (
        .cons_valid  (cons.valid),
        .cons_fwd_en (cons.fwd_en),
        .src         (sel_src),
        .prod        (prods[e]),
        .stall       (chk_stall[e*NUM_OPND+o])
      );
    end
  end

  assign own_stall = |chk_stall;

endmodule

// File: rtl/hazard_stall_unit.sv
`timescale 1ns/1ps
module hazard_stall_unit
  import hazard_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned NUM_EX    = 2
) (
  input  logic [NUM_SLOTS-1:0]          dec_valid,
  input  logic [NUM_SLOTS-1:0]          dec_fwd_en,
  input  logic [NUM_SLOTS*REG_ID_W-1:0] dec_srca_id,
  input  logic [NUM_SLOTS-1:0]          dec_srca_rd,
  input  logic [NUM_SLOTS-1:0]          dec_srca_long,
  input  logic [NUM_SLOTS*REG_ID_W-1:0] dec_srcb_id,
  input  logic [NUM_SLOTS-1:0]          dec_srcb_rd,
  input  logic [NUM_SLOTS-1:0]          dec_srcb_long,
  input  logic [NUM_EX-1:0]             ex_valid,
  input  logic [NUM_EX*REG_ID_W-1:0]    ex_dst_id,
  input  logic [NUM_EX-1:0]             ex_wr_en,
  input  logic [NUM_EX-1:0]             ex_long,
  input  logic [NUM_EX-1:0]             ex_two_cyc,
  output logic [NUM_SLOTS-1:0]          slot_stall,
  output logic                          decode_stall
);

  consumer_t [NUM_SLOTS-1:0] cons;
  producer_t [NUM_EX-1:0]    prods;
  logic      [NUM_SLOTS-1:0] own_stall;

  for (genvar e = 0; e < NUM_EX; e++) begin : g_prod
    assign prods[e].valid   = ex_valid[e];
    assign prods[e].dst     = ex_dst_id[e*REG_ID_W +: REG_ID_W];
    assign prods[e].wr_en   = ex_wr_en[e];
    assign prods[e].is_long = ex_long[e];
    assign prods[e].two_cyc = ex_two_cyc[e];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign cons[s].valid       = dec_valid[s];
    assign cons[s].fwd_en      = dec_fwd_en[s];
    assign cons[s].opa.id      = dec_srca_id[s*REG_ID_W +: REG_ID_W];
    assign cons[s].opa.rd_en   = dec_srca_rd[s];
    assign cons[s].opa.is_long = dec_srca_long[s];
    assign cons[s].opb.id      = dec_srcb_id[s*REG_ID_W +: REG_ID_W];
    assign cons[s].opb.rd_en   = dec_srcb_rd[s];
    assign cons[s].opb.is_long = dec_srcb_long[s];

    hz_slot_check #(.NUM_EX(NUM_EX)) u_slot (
      .cons      (cons[s]),
      .prods     (prods),
      .own_stall (own_stall[s])
    );

    // in-order issue: a younger slot holds behind an older one
    if (s == 0) begin : g_head
      assign slot_stall[s] = own_stall[s];
    end else begin : g_chain
      assign slot_stall[s] = own_stall[s] | slot_stall[s-1];
    end
  end

  assign decode_stall = slot_stall[NUM_SLOTS-1];

endmodule

// File: rtl/hazard_stall_unit_chk.sv
`timescale 1ns/1ps
module hazard_stall_unit_chk #(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned NUM_EX    = 2
) (
  input logic [NUM_SLOTS-1:0] dec_valid,
  input logic [NUM_SLOTS-1:0] dec_srca_rd,
  input logic [NUM_SLOTS-1:0] dec_srcb_rd,
  input logic [NUM_EX-1:0]    ex_valid,
  input logic [NUM_EX-1:0]    ex_wr_en,
  input logic [NUM_SLOTS-1:0] slot_stall,
  input logic                 decode_stall
);

  always_comb begin
    // R11: global stall reflects any slot stall
    assert_global_or_R11: assert (decode_stall == (|slot_stall));
    // R4: bubbles in every execute stage never cause a hold
    if (ex_valid == '0) begin
      assert_bubble_free_R4: assert (slot_stall == '0);
    end
    // R4: without a writer there is nothing to wait for
    if (ex_wr_en == '0) begin
      assert_no_writer_R4: assert (slot_stall == '0);
    end
    // R4: with no source read there is no dependency
    if ((dec_srca_rd | dec_srcb_rd) == '0) begin
      assert_no_reader_R4: assert (slot_stall == '0);
    end
    // R4: an empty head slot never holds
    if (!dec_valid[0]) begin
      assert_empty_head_R4: assert (!slot_stall[0]);
    end
  end

  for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_order
    always_comb begin
      // R10: in-order issue
      if (slot_stall[s-1]) begin
        assert_in_order_R10: assert (slot_stall[s]);
      end
    end
  end

endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .NUM_EX    (NUM_EX)
) u_hazard_stall_unit_chk (.*);

// File: tb/hazard_stall_unit_bench.sv
`timescale 1ns/1ps
module hazard_stall_unit_bench;

  localparam int NS = 2;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic [NS-1:0]   dec_valid, dec_fwd_en, dec_srca_rd, dec_srca_long;
  logic [NS-1:0]   dec_srcb_rd, dec_srcb_long;
  logic [NS*4-1:0] dec_srca_id, dec_srcb_id;
  logic [NE-1:0]   ex_valid, ex_wr_en, ex_long, ex_two_cyc;
  logic [NE*4-1:0] ex_dst_id;
  logic [NS-1:0]   slot_stall;
  logic            decode_stall;

  int    checks = 0;
  int    failures = 0;
  bit    chk_en = 0;
  bit    done = 0;
  string cur_tag = "R4";

  always #2.5 clk = ~clk;

  hazard_stall_unit #(.NUM_SLOTS(NS), .NUM_EX(NE)) u_hazard_stall_unit (
    .dec_valid     (dec_valid),
    .dec_fwd_en    (dec_fwd_en),
    .dec_srca_id   (dec_srca_id),
    .dec_srca_rd   (dec_srca_rd),
    .dec_srca_long (dec_srca_long),
    .dec_srcb_id   (dec_srcb_id),
    .dec_srcb_rd   (dec_srcb_rd),
    .dec_srcb_long (dec_srcb_long),
    .ex_valid      (ex_valid),
    .ex_dst_id     (ex_dst_id),
    .ex_wr_en      (ex_wr_en),
    .ex_long       (ex_long),
    .ex_two_cyc    (ex_two_cyc),
    .slot_stall    (slot_stall),
    .decode_stall  (decode_stall)
  );

  // registers covered by each value, intersected as sets
  function automatic bit overlap(int s, bit sl, int d, bit dl);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++)
        if ((i == 0 || sl) && (j == 0 || dl) && ((s + i) == (d + j))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [NS-1:0] model();
    logic [NS-1:0] r = '0;
    bit held = 0;
    for (int s = 0; s < NS; s++) begin
      bit own = 0;
      for (int e = 0; e < NE; e++) begin
        for (int op = 0; op < 2; op++) begin
          int sid = op ? int'(dec_srcb_id[s*4 +: 4]) : int'(dec_srca_id[s*4 +: 4]);
          bit rd  = op ? dec_srcb_rd[s] : dec_srca_rd[s];
          bit lg  = op ? dec_srcb_long[s] : dec_srca_long[s];
          if (dec_valid[s] && ex_valid[e] && ex_wr_en[e] && rd &&
              overlap(sid, lg, int'(ex_dst_id[e*4 +: 4]), ex_long[e])) begin
            if (!dec_fwd_en[s] || ex_two_cyc[e] || (lg != ex_long[e])) own = 1;
          end
        end
      end
      held = held | own;
      r[s] = held;
    end
    return r;
  endfunction

  // results are combinational: compared half a cycle after each new pattern
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      logic [NS-1:0] exp_s;
      exp_s = model();
      for (int s = 0; s < NS; s++) begin
        checks++;
        if (slot_stall[s] !== exp_s[s]) begin
          failures++;
          $display("FAIL %s R12 slot_stall[%0d] actual=%b expected=%b", cur_tag, s, slot_stall[s], exp_s[s]);
        end
      end
      checks++;
      if (decode_stall !== (|exp_s)) begin
        failures++;
        $display("FAIL %s R11 decode_stall actual=%b expected=%b", cur_tag, decode_stall, |exp_s);
      end
    end
  end

  task automatic clr();
    dec_valid = '1; dec_fwd_en = '1;
    dec_srca_id = '0; dec_srca_rd = '0; dec_srca_long = '0;
    dec_srcb_id = '0; dec_srcb_rd = '0; dec_srcb_long = '0;
    ex_valid = '0; ex_dst_id = '0; ex_wr_en = '0; ex_long = '0; ex_two_cyc = '0;
  endtask

  task automatic prod(int e, int dst, bit lg, bit two);
    ex_valid[e] = 1'b1; ex_wr_en[e] = 1'b1;
    ex_dst_id[e*4 +: 4] = 4'(dst); ex_long[e] = lg; ex_two_cyc[e] = two;
  endtask

  task automatic src(int s, int op, int id, bit lg);
    if (op == 0) begin
      dec_srca_id[s*4 +: 4] = 4'(id); dec_srca_rd[s] = 1'b1; dec_srca_long[s] = lg;
    end else begin
      dec_srcb_id[s*4 +: 4] = 4'(id); dec_srcb_rd[s] = 1'b1; dec_srcb_long[s] = lg;
    end
  endtask

  task automatic next(string tag);
    @(posedge clk);
    clr();
    cur_tag = tag;
  endtask

  // one width/stall case on a given slot, operand and stage
  task automatic one_case(string tag, int s, int op, int e, int sid, bit sl,
                          int did, bit dl, bit fwd, bit two);
    next(tag);
    src(s, op, sid, sl);
    prod(e, did, dl, two);
    dec_fwd_en[s] = fwd;
  endtask

  initial begin
    clr();
    dec_valid = '0; dec_fwd_en = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    chk_en = 1'b1;
    next("R4");                                   // quiet state after reset
    for (int e = 0; e < NE; e++) begin
      for (int op = 0; op < 2; op++) begin
        for (int s = 0; s < NS; s++) begin
          one_case("R1", s, op, e, 5, 0, 5, 0, 0, 0);  // short/short hit
          one_case("R1", s, op, e, 5, 0, 6, 0, 0, 0);  // short/short miss
          one_case("R1", s, op, e, 4, 1, 4, 1, 0, 0);  // long/long hit
          one_case("R1", s, op, e, 4, 1, 6, 1, 0, 0);  // long/long miss
          one_case("R2", s, op, e, 6, 1, 7, 0, 0, 0);  // long src, short dst upper
          one_case("R2", s, op, e, 6, 1, 6, 0, 0, 0);  // long src, short dst lower
          one_case("R2", s, op, e, 6, 1, 8, 0, 0, 0);  // miss
          one_case("R3", s, op, e, 3, 0, 2, 1, 0, 0);  // short src in upper half
          one_case("R3", s, op, e, 2, 0, 2, 1, 0, 0);
          one_case("R3", s, op, e, 4, 0, 2, 1, 0, 0);  // miss
          one_case("R5", s, op, e, 9, 0, 9, 0, 0, 0);
          one_case("R6", s, op, e, 9, 0, 9, 0, 1, 1);
          one_case("R7", s, op, e, 6, 1, 7, 0, 1, 0);
          one_case("R7", s, op, e, 3, 0, 2, 1, 1, 0);
          one_case("R8", s, op, e, 9, 0, 9, 0, 1, 0);
          one_case("R8", s, op, e, 10, 1, 10, 1, 1, 0);
          one_case("R9", s, op, e, 12, 0, 12, 1, 1, 0);
          // R4: each qualifier removed in turn
          one_case("R4", s, op, e, 5, 0, 5, 0, 0, 0);
          if (op == 0) dec_srca_rd[s] = 0; else dec_srcb_rd[s] = 0;
          one_case("R4", s, op, e, 5, 0, 5, 0, 0, 0); ex_wr_en[e] = 0;
          one_case("R4", s, op, e, 5, 0, 5, 0, 0, 0); ex_valid[e] = 0;
          one_case("R4", s, op, e, 5, 0, 5, 0, 0, 0); dec_valid[s] = 0;
        end
      end
    end
    // R10: head holds, tail independent; then tail alone
    next("R10"); src(0, 0, 3, 0); prod(0, 3, 0, 1); src(1, 1, 11, 0);
    next("R10"); src(1, 0, 3, 0); prod(1, 3, 0, 1); src(0, 1, 11, 0);
    next("R11"); src(0, 1, 7, 0); src(1, 0, 7, 0); prod(1, 7, 0, 0); dec_fwd_en = 2'b10;
    // random mixes with small id ranges
    for (int n = 0; n < 3000; n++) begin
      next("R9");
      dec_valid = 2'($urandom); dec_fwd_en = 2'($urandom);
      ex_valid = 2'($urandom); ex_wr_en = 2'($urandom); ex_two_cyc = 2'($urandom);
      for (int s = 0; s < NS; s++) begin
        for (int op = 0; op < 2; op++) begin
          bit lg = 1'($urandom);
          int id = $urandom_range(0, 5);
          if (lg) id = id & ~1;
          src(s, op, id, lg);
          if ($urandom_range(0, 3) == 0) begin
            if (op == 0) dec_srca_rd[s] = 0; else dec_srcb_rd[s] = 0;
          end
        end
      end
      for (int e = 0; e < NE; e++) begin
        bit lg = 1'($urandom);
        int id = $urandom_range(0, 5);
        if (lg) id = id & ~1;
        ex_dst_id[e*4 +: 4] = 4'(id); ex_long[e] = lg;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk_en = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R12 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule